// File: doc/BRIEF.md
# Convoy Formation Negotiator

This block runs the per-vehicle side of a protocol that assembles a convoy over a shared message channel. After reset it hunts for partners by broadcasting a seek message at a programmable interval. When some vehicle answers, it judges whether the pair can travel together, using a range-acceptable flag and a direction-compatible flag supplied by the surrounding system. If the pair is compatible it announces the join and settles the roles. The vehicle with the strictly lower identifier leads. The leader forwards a speed setpoint to its speed loop, and the follower enables its spacing loop.

A pairing that fails the range or direction test is turned down with an explicit refusal message. A pairing abandoned by the peer sends the block back to seeking, and so does a pairing that goes silent while the join is pending. Once the convoy is formed, a leave message or a link-loss message from the peer ends it. The block then drops both control enables and starts seeking again. The continuous speed and spacing controllers live outside this block. It only decides which of them runs, and with what setpoint.

Top module: `platoon_former`

## Requirements
- R1: While reset is asserted and right after it, the state output is seeking (0), tx_valid is 0, tx_code is 0, speed_en and gap_en are 0 and speed_target is 0; asserting reset in any state returns to this condition.
- R2: In the seeking state a seek message (code 1) is sent as a one-cycle tx_valid pulse every P cycles, with P = cfg_period and a value of 0 treated as 1. The first pulse appears P clock edges after the seeking state is entered.
- R3: In seeking, a received answer (code 2) moves the state to evaluating (1) on the next edge and captures rx_id as the peer identifier. An answer takes priority over a seek due in the same cycle, and any other received code leaves the state unchanged.
- R4: The evaluating state lasts exactly one cycle. If dist_ok and head_ok are both 1, a join message (code 4) is sent, the state becomes pending (2), the leader decision (own_id strictly lower than peer) is recorded and calc_speed is latched. Otherwise a refusal (code 3) is sent and the state returns to seeking.
- R5: In pending, a received join (code 4) while leader moves to leading (3). There speed_en is 1, gap_en is 0 and speed_target holds the value latched during evaluation; speed_target is 0 whenever speed_en is 0.
- R6: In pending, a received join while not leader (including equal identifiers) moves to following (4), with gap_en 1 and speed_en 0.
- R7: In pending, a received refusal (code 3) returns to seeking on the next edge. With no join or refusal received, the state returns to seeking P edges after pending was entered.
- R8: In leading or following, a received leave (code 5) or link-loss (code 6) returns to seeking on the next edge with both enables low; other codes are ignored there.
- R9: The state output encodes seeking 0, evaluating 1, pending 2, leading 3, following 4, and speed_en and gap_en are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_period | input | CNT_W | Seek interval and pending timeout in cycles (0 acts as 1) |
| own_id | input | ID_W | This vehicle's identifier |
| rx_valid | input | 1 | Received message strobe |
| rx_code | input | 3 | Received message code |
| rx_id | input | ID_W | Sender identifier of the received message |
| dist_ok | input | 1 | Range to the peer allows convoy formation |
| head_ok | input | 1 | Heading of the peer allows convoy formation |
| calc_speed | input | SPD_W | Computed convoy speed offered to the leader |
| tx_valid | output | 1 | Transmit strobe, one cycle per message |
| tx_code | output | 3 | Transmitted message code, 0 when idle |
| speed_en | output | 1 | Speed-control loop enable (leading) |
| speed_target | output | SPD_W | Speed setpoint for the speed loop |
| gap_en | output | 1 | Spacing-control loop enable (following) |
| state_o | output | 3 | Current protocol state code |

## Verification
The bench builds the block with CNT_W=8, ID_W=4 and SPD_W=8. The 4-bit identifier space puts the extreme peers 0 and 15 and an identifier equal to the vehicle's own within a short table. Periods of 0, 4, 5 and 50 are programmed at reset. These settle the zero-as-one rule, the exact seek spacing, the pending timeout edge and a seek falling due in the same cycle as an answer. The long period keeps the table walk free of unrelated seek pulses.

// File: rtl/platoon_pkg.sv
package platoon_pkg;

  typedef enum logic [2:0] {
    ST_SEEK   = 3'd0,
    ST_EVAL   = 3'd1,
    ST_PEND   = 3'd2,
    ST_LEAD   = 3'd3,
    ST_FOLLOW = 3'd4
  } pf_state_e;

  typedef enum logic [2:0] {
    MSG_NONE   = 3'd0,
    MSG_SEEK   = 3'd1,
    MSG_ANSWER = 3'd2,
    MSG_REFUSE = 3'd3,
    MSG_JOIN   = 3'd4,
    MSG_LEAVE  = 3'd5,
    MSG_LOST   = 3'd6
  } pf_msg_e;

endpackage

// File: rtl/pf_interval_timer.sv
module pf_interval_timer #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             clear,
  input  logic [CNT_W-1:0] period,
  output logic             tick
);

  // zero is treated as the shortest interval
  function automatic logic [CNT_W-1:0] last_count(input logic [CNT_W-1:0] p);
    return (p == '0) ? '0 : p - 1'b1;
  endfunction

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_limit;

  assign cnt_limit = last_count(period);
  assign tick      = run && (cnt_q >= cnt_limit);

  always_ff @(posedge clk) begin
    if (!rst_n)                      cnt_q <= '0;
    else if (!run || clear || tick)  cnt_q <= '0;
    else                             cnt_q <= cnt_q + 1'b1;
  end

  AST_IDLE_CNT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (!run || clear) |=> (cnt_q == '0)); // R2

endmodule

// File: rtl/pf_pair_judge.sv
module pf_pair_judge #(
  parameter int ID_W = 8
) (
  input  logic [ID_W-1:0] own_id,
  input  logic [ID_W-1:0] peer_id,
  input  logic            dist_ok,
  input  logic            head_ok,
  output logic            eligible,
  output logic            wins_lead
);

  function automatic logic pair_fits(input logic d, input logic h);
    return d & h;
  endfunction

  // strictly lower identifier leads; a tie yields the follower role
  function automatic logic lower_leads(input logic [ID_W-1:0] mine,
                                       input logic [ID_W-1:0] theirs);
    return mine < theirs;
  endfunction

  assign eligible  = pair_fits(dist_ok, head_ok);
  assign wins_lead = lower_leads(own_id, peer_id);

endmodule

// File: rtl/pf_protocol_fsm.sv
module pf_protocol_fsm
  import platoon_pkg::*;
#(
  parameter int ID_W  = 8,
  parameter int SPD_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rx_valid,
  input  logic [2:0]       rx_code,
  input  logic [ID_W-1:0]  rx_id,
  input  logic [SPD_W-1:0] calc_speed,
  input  logic             tick,
  input  logic             eligible,
  input  logic             wins_lead,
  output logic [ID_W-1:0]  peer_id,
  output logic             timer_run,
  output logic             state_chg,
  output logic             tx_valid,
  output logic [2:0]       tx_code,
  output logic             speed_en,
  output logic [SPD_W-1:0] speed_target,
  output logic             gap_en,
  output logic [2:0]       state_o
);

  pf_state_e        state_q, state_d;
  logic [ID_W-1:0]  peer_q;
  logic             lead_q;
  logic [SPD_W-1:0] spd_q;
  logic             txv_q, txv_d;
  logic [2:0]       txc_q, txc_d;
  logic             cap_peer, cap_pair;

  // named events for the checks
  logic ev_answer, ev_join_rx, ev_refuse_rx, ev_drop;
  assign ev_answer    = rx_valid && (rx_code == MSG_ANSWER);
  assign ev_join_rx   = rx_valid && (rx_code == MSG_JOIN);
  assign ev_refuse_rx = rx_valid && (rx_code == MSG_REFUSE);
  assign ev_drop      = rx_valid && ((rx_code == MSG_LEAVE) || (rx_code == MSG_LOST));

  always_comb begin
    state_d  = state_q;
    txv_d    = 1'b0;
    txc_d    = MSG_NONE;
    cap_peer = 1'b0;
    cap_pair = 1'b0;
    unique case (state_q)
      ST_SEEK: begin
        if (ev_answer) begin
          state_d  = ST_EVAL;
          cap_peer = 1'b1;
        end else if (tick) begin
          txv_d = 1'b1;
          txc_d = MSG_SEEK;
        end
      end
      ST_EVAL: begin
        txv_d = 1'b1;
        if (eligible) begin
          txc_d    = MSG_JOIN;
          state_d  = ST_PEND;
          cap_pair = 1'b1;
        end else begin
          txc_d   = MSG_REFUSE;
          state_d = ST_SEEK;
        end
      end
      ST_PEND: begin
        if (ev_join_rx)        state_d = lead_q ? ST_LEAD : ST_FOLLOW;
        else if (ev_refuse_rx) state_d = ST_SEEK;
        else if (tick)         state_d = ST_SEEK;
      end
      ST_LEAD, ST_FOLLOW: begin
        if (ev_drop) state_d = ST_SEEK;
      end
      default: state_d = ST_SEEK;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_SEEK;
      peer_q  <= '0;
      lead_q  <= 1'b0;
      spd_q   <= '0;
      txv_q   <= 1'b0;
      txc_q   <= MSG_NONE;
    end else begin
      state_q <= state_d;
      txv_q   <= txv_d;
      txc_q   <= txc_d;
      if (cap_peer) peer_q <= rx_id;
      if (cap_pair) begin
        lead_q <= wins_lead;
        spd_q  <= calc_speed;
      end
    end
  end

  assign peer_id      = peer_q;
  assign timer_run    = (state_q == ST_SEEK) || (state_q == ST_PEND);
  assign state_chg    = (state_d != state_q);
  assign tx_valid     = txv_q;
  assign tx_code      = txc_q;
  assign speed_en     = (state_q == ST_LEAD);
  assign gap_en       = (state_q == ST_FOLLOW);
  assign speed_target = (state_q == ST_LEAD) ? spd_q : '0;
  assign state_o      = state_q;

  AST_EVAL_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_EVAL) |=> (state_q != ST_EVAL)); // R4

  AST_SEEK_ANSWER_TO_EVAL: assert property (@(posedge clk) disable iff (!rst_n)
    ((state_q == ST_SEEK) && ev_answer) |=> ((state_q == ST_EVAL) && !tx_valid)); // R3

  AST_REFUSE_TX_IN_SEEK: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && (tx_code == MSG_REFUSE)) |-> (state_q == ST_SEEK)); // R4

  AST_SEEK_TX_IN_SEEK: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && (tx_code == MSG_SEEK)) |-> (state_q == ST_SEEK)); // R2

  AST_JOIN_TX_IN_PEND: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && (tx_code == MSG_JOIN)) |-> (state_q == ST_PEND)); // R4

  AST_DROP_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
    (((state_q == ST_LEAD) || (state_q == ST_FOLLOW)) && ev_drop)
      |=> ((state_q == ST_SEEK) && !speed_en && !gap_en)); // R8

  AST_PEND_REFUSE_SEEK: assert property (@(posedge clk) disable iff (!rst_n)
    ((state_q == ST_PEND) && ev_refuse_rx && !ev_join_rx) |=> (state_q == ST_SEEK)); // R7

endmodule

// File: rtl/platoon_former.sv
module platoon_former
  import platoon_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int ID_W  = 8,
  parameter int SPD_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] cfg_period,
  input  logic [ID_W-1:0]  own_id,
  input  logic             rx_valid,
  input  logic [2:0]       rx_code,
  input  logic [ID_W-1:0]  rx_id,
  input  logic             dist_ok,
  input  logic             head_ok,
  input  logic [SPD_W-1:0] calc_speed,
  output logic             tx_valid,
  output logic [2:0]       tx_code,
  output logic             speed_en,
  output logic [SPD_W-1:0] speed_target,
  output logic             gap_en,
  output logic [2:0]       state_o
);

  logic            tick, timer_run, state_chg;
  logic            eligible, wins_lead;
  logic [ID_W-1:0] peer_id;

  pf_interval_timer #(.CNT_W(CNT_W)) u_timer (
    .clk    (clk),
    .rst_n  (rst_n),
    .run    (timer_run),
    .clear  (state_chg),
    .period (cfg_period),
    .tick   (tick)
  );

  pf_pair_judge #(.ID_W(ID_W)) u_judge (
    .own_id    (own_id),
    .peer_id   (peer_id),
    .dist_ok   (dist_ok),
    .head_ok   (head_ok),
    .eligible  (eligible),
    .wins_lead (wins_lead)
  );

  pf_protocol_fsm #(.ID_W(ID_W), .SPD_W(SPD_W)) u_fsm (
    .clk          (clk),
    .rst_n        (rst_n),
    .rx_valid     (rx_valid),
    .rx_code      (rx_code),
    .rx_id        (rx_id),
    .calc_speed   (calc_speed),
    .tick         (tick),
    .eligible     (eligible),
    .wins_lead    (wins_lead),
    .peer_id      (peer_id),
    .timer_run    (timer_run),
    .state_chg    (state_chg),
    .tx_valid     (tx_valid),
    .tx_code      (tx_code),
    .speed_en     (speed_en),
    .speed_target (speed_target),
    .gap_en       (gap_en),
    .state_o      (state_o)
  );

  AST_ENABLES_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(speed_en && gap_en)); // R9

  AST_SPEED_ZERO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !speed_en |-> (speed_target == '0)); // R5

  AST_TX_CODE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_valid |-> (tx_code == 3'd0)); // R2

endmodule

// File: tb/tb_platoon_former.sv
module tb_platoon_former;

  localparam int CNT_W = 8;
  localparam int ID_W  = 4;
  localparam int SPD_W = 8;
  localparam logic [ID_W-1:0] OWN = 4'd7;

  // row: {pad9, final_state3, eval_tx3, reply3, speed8, head1, dist1, peer4}
  localparam int NROW = 8;
  localparam logic [31:0] ROWS [NROW] = '{
    {9'd0, 3'd3, 3'd4, 3'd4, 8'd40,  1'b1, 1'b1, 4'd9},
    {9'd0, 3'd4, 3'd4, 3'd4, 8'd55,  1'b1, 1'b1, 4'd2},
    {9'd0, 3'd4, 3'd4, 3'd4, 8'd10,  1'b1, 1'b1, 4'd7},
    {9'd0, 3'd0, 3'd3, 3'd0, 8'd33,  1'b1, 1'b0, 4'd12},
    {9'd0, 3'd0, 3'd3, 3'd0, 8'd33,  1'b0, 1'b1, 4'd12},
    {9'd0, 3'd0, 3'd4, 3'd3, 8'd200, 1'b1, 1'b1, 4'd15},
    {9'd0, 3'd4, 3'd4, 3'd4, 8'd99,  1'b1, 1'b1, 4'd0},
    {9'd0, 3'd3, 3'd4, 3'd4, 8'd255, 1'b1, 1'b1, 4'd8}
  };

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic [CNT_W-1:0] cfg_period = 8'd50;
  logic [ID_W-1:0]  own_id = OWN;
  logic             rx_valid = 1'b0;
  logic [2:0]       rx_code = 3'd0;
  logic [ID_W-1:0]  rx_id = '0;
  logic             dist_ok = 1'b0;
  logic             head_ok = 1'b0;
  logic [SPD_W-1:0] calc_speed = '0;
  logic             tx_valid;
  logic [2:0]       tx_code;
  logic             speed_en;
  logic [SPD_W-1:0] speed_target;
  logic             gap_en;
  logic [2:0]       state_o;

  int errors = 0;
  int checks = 0;

  always #10 clk = ~clk;

  platoon_former #(.CNT_W(CNT_W), .ID_W(ID_W), .SPD_W(SPD_W)) dut (
    .clk(clk), .rst_n(rst_n), .cfg_period(cfg_period), .own_id(own_id),
    .rx_valid(rx_valid), .rx_code(rx_code), .rx_id(rx_id),
    .dist_ok(dist_ok), .head_ok(head_ok), .calc_speed(calc_speed),
    .tx_valid(tx_valid), .tx_code(tx_code), .speed_en(speed_en),
    .speed_target(speed_target), .gap_en(gap_en), .state_o(state_o)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic do_reset(input logic [CNT_W-1:0] p);
    @(negedge clk);
    rst_n = 1'b0;
    cfg_period = p;
    rx_valid = 1'b0; rx_code = 3'd0; dist_ok = 1'b0; head_ok = 1'b0;
    step(); step();
    rst_n = 1'b1;
  endtask

  task automatic send(input logic [2:0] code, input logic [ID_W-1:0] id);
    rx_valid = 1'b1; rx_code = code; rx_id = id;
    step();
    rx_valid = 1'b0; rx_code = 3'd0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=expired expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    // R1 reset state, R9 encoding
    @(negedge clk);
    rst_n = 1'b0;
    step();
    chk("R1 state in reset", state_o, 0);
    chk("R1 tx_valid in reset", tx_valid, 0);
    chk("R1 tx_code in reset", tx_code, 0);
    chk("R1 speed_en in reset", speed_en, 0);
    chk("R1 gap_en in reset", gap_en, 0);
    chk("R1 speed_target in reset", speed_target, 0);

    // table walk, long period keeps seek pulses away
    do_reset(8'd50);
    for (int r = 0; r < NROW; r++) begin
      logic [31:0] v;
      int exp_spd;
      v = ROWS[r];
      send(3'd2, v[3:0]);
      chk("R3 answer enters evaluating", state_o, 1);
      dist_ok = v[4]; head_ok = v[5]; calc_speed = v[13:6];
      step();
      dist_ok = 1'b0; head_ok = 1'b0; calc_speed = 8'hA5;
      chk("R4 evaluation tx_valid", tx_valid, 1);
      chk("R4 evaluation tx_code", tx_code, int'(v[19:17]));
      chk("R4 state after evaluation", state_o, (v[19:17] == 3'd4) ? 2 : 0);
      if (v[19:17] == 3'd4) begin
        send(v[16:14], 4'd1);
        exp_spd = (v[22:20] == 3'd3) ? int'(v[13:6]) : 0;
        chk("R5 R6 R7 state after reply", state_o, int'(v[22:20]));
        chk("R5 speed_en", speed_en, (v[22:20] == 3'd3) ? 1 : 0);
        chk("R6 gap_en", gap_en, (v[22:20] == 3'd4) ? 1 : 0);
        chk("R5 speed_target latched", speed_target, exp_spd);
        if (v[22:20] != 3'd0) begin
          send((r % 2 == 0) ? 3'd5 : 3'd6, 4'd1);
          chk("R8 drop returns to seeking", state_o, 0);
          chk("R8 enables released", {30'd0, speed_en, gap_en}, 0);
        end
      end
    end

    // R2 periodic seek with P=5
    do_reset(8'd5);
    for (int k = 1; k <= 12; k++) begin
      step();
      chk("R2 seek pulse timing", tx_valid, (k % 5 == 0) ? 1 : 0);
      if (k % 5 == 0) chk("R2 seek code", tx_code, 1);
    end

    // R2 zero period acts as one
    do_reset(8'd0);
    for (int k = 1; k <= 3; k++) begin
      step();
      chk("R2 zero period every cycle", tx_valid, 1);
    end

    // R3 answer beats a seek due in the same cycle, and ignored codes
    do_reset(8'd5);
    send(3'd4, 4'd3);
    chk("R3 join ignored while seeking", state_o, 0);
    step(); step(); step();
    send(3'd2, 4'd9);
    chk("R3 answer wins over due seek state", state_o, 1);
    chk("R3 answer wins over due seek tx", tx_valid, 0);

    // R7 pending timeout with P=4
    do_reset(8'd4);
    send(3'd2, 4'd9);
    dist_ok = 1'b1; head_ok = 1'b1; calc_speed = 8'd77;
    step();
    dist_ok = 1'b0; head_ok = 1'b0;
    chk("R7 pending entered", state_o, 2);
    for (int k = 1; k <= 4; k++) begin
      step();
      chk("R7 pending timeout", state_o, (k < 4) ? 2 : 0);
    end

    // R8 other codes ignored while leading, R1 reset from leading
    do_reset(8'd50);
    send(3'd2, 4'd11);
    dist_ok = 1'b1; head_ok = 1'b1; calc_speed = 8'd60;
    step();
    dist_ok = 1'b0; head_ok = 1'b0;
    send(3'd4, 4'd11);
    chk("R5 leading reached", state_o, 3);
    send(3'd1, 4'd11);
    send(3'd2, 4'd11);
    send(3'd3, 4'd11);
    chk("R8 other codes ignored state", state_o, 3);
    chk("R8 other codes ignored speed", speed_target, 60);
    rst_n = 1'b0;
    step();
    chk("R1 reset from leading state", state_o, 0);
    chk("R1 reset from leading speed_en", speed_en, 0);
    rst_n = 1'b1;

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule